// File: doc/BRIEF.md
# Nibble-Prefix Instruction Operand Decoder

This block sits between an instruction-byte fetcher and an execution stage. Each incoming byte carries a primary function code in its upper four bits and a four-bit immediate in its lower four bits. Operands wider than four bits are not held in fixed fields. Instead, one or more prefix bytes come before the instruction, and each one folds its nibble into an internal 32-bit operand register and shifts it up by four bits. A positive prefix (function code 0x2) builds ordinary constants. A negative prefix (function code 0x6) complements the value it has built, which is how negative operands are formed.

Prefix bytes produce no output. Every other byte completes an instruction. For it the block emits one record holding the function code and the full operand, and then clears the operand register. When the function code is the operate code (0xF), the completed operand is read as an extended zero-operand opcode, not as a constant. The record then also marks the operate case, gives the low four bits of the opcode, and flags opcodes outside the first sixteen.

Bytes arrive over a valid/ready handshake. Records leave through a one-entry output register that also uses valid/ready. A flush input, driven on taken jumps, throws away a partly built operand and any record that has not yet been taken.

Top module: `opnd_decoder`

## Requirements
- R1: The function code of a byte is bits [7:4] and its immediate is bits [3:0]. A non-prefix byte with no prefix before it emits `out_func` equal to bits [7:4] and `out_operand` equal to bits [3:0] zero-extended to 32 bits.
- R2: An accepted byte with function code 0x2 sets the operand register to (register OR nibble) shifted left by 4 and emits no record.
- R3: An accepted byte with function code 0x6 sets the operand register to the bitwise complement of (register OR nibble), shifted left by 4, and emits no record.
- R4: An accepted byte with any other function code emits `out_operand` = (register OR nibble) and then clears the operand register to zero.
- R5: In a record whose function code is 0xF, `out_is_op` is 1, `out_op_code` equals `out_operand[3:0]`, and `out_op_ext` is 1 exactly when `out_operand` is 16 or more. For every other function code, `out_is_op` is 0.
- R6: The operand register is 32 bits wide. In a long prefix chain, bits shifted past bit 31 are lost and no error is raised.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, the record on the output ports stays unchanged, and the operand register is not updated.
- R8: While `flush` is 1, `in_ready` is 0. One cycle after `flush`, the operand register is zero and `out_valid` is 0.
- R9: While reset is asserted and after it is released, `out_valid` is 0, `in_ready` is 1, and the operand register is zero.
- R10: A record appears on the output ports one cycle after its byte is accepted. `out_valid` falls after the record is taken if no new record is loaded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush | input | 1 | Drops the partial operand and any pending record |
| in_valid | input | 1 | Instruction byte is offered |
| in_byte | input | 8 | Instruction byte: function code in [7:4], immediate in [3:0] |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_func | output | 4 | Function code of the record |
| out_operand | output | 32 | Completed operand |
| out_is_op | output | 1 | Function code is the operate code 0xF |
| out_op_code | output | 4 | Low four bits of the extended opcode |
| out_op_ext | output | 1 | Extended opcode is outside the first sixteen |

## Verification
A corrupted operand register cannot be seen while a prefix chain is being built. It shows up only in the operand of the next non-prefix record, one cycle after that byte is accepted. For this reason the bench ends every prefix chain with a record and compares the full 32-bit value. If the register failed to clear after an emit, the stale bits would appear in the operand of the following single-byte instruction. If the stall logic let a byte in while the output was blocked, the prefix would either be dropped or applied twice, and the mistake would appear in the record after the stall is released.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [NIB_W-1:0] {
    FN_BRANCH   = 4'h0,
    FN_WSPTR    = 4'h1,
    FN_PFX_POS  = 4'h2,
    FN_RDIND    = 4'h3,
    FN_CONST    = 4'h4,
    FN_INDPTR   = 4'h5,
    FN_PFX_NEG  = 4'h6,
    FN_RDWS     = 4'h7,
    FN_ADDK     = 4'h8,
    FN_SUBR     = 4'h9,
    FN_CBRANCH  = 4'hA,
    FN_WSMOVE   = 4'hB,
    FN_CMPK     = 4'hC,
    FN_WRWS     = 4'hD,
    FN_WRIND    = 4'hE,
    FN_OPERATE  = 4'hF
  } func_e;
endpackage

// File: rtl/opd_accum.sv
module opd_accum
  import opd_pkg::*;
#(
  parameter int unsigned OPW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             flush,
  input  logic [BYTE_W-1:0] byte_i,
  output logic             prefix_o,
  output logic [OPW-1:0]   operand_o
);
  localparam int unsigned PADW = OPW - NIB_W;

  logic [OPW-1:0] oreg_q, oreg_d, merged;
  logic [NIB_W-1:0] nib;
  func_e fn;
  logic is_pos, is_neg, ld_en;

  always_comb begin
    fn     = func_e'(byte_i[BYTE_W-1:NIB_W]);
    nib    = byte_i[NIB_W-1:0];
    is_pos = (fn == FN_PFX_POS);
    is_neg = (fn == FN_PFX_NEG);
    merged = oreg_q | {{PADW{1'b0}}, nib};
  end

  assign prefix_o  = is_pos | is_neg;
  assign operand_o = merged;
  assign ld_en     = flush | take;

  always_comb begin
    oreg_d = oreg_q;
    if (flush)       oreg_d = '0;
    else if (is_pos) oreg_d = merged << NIB_W;
    else if (is_neg) oreg_d = (~merged) << NIB_W;
    else             oreg_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oreg_q <= '0;
    else if (ld_en) oreg_q <= oreg_d;
  end

  // R4: register is cleared once a completing byte is accepted
  a_r4_clear_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !prefix_o && !flush) |=> (oreg_q == '0));
  // R2 / R3: a prefix always leaves an empty low nibble for the next byte
  a_r2_low_nibble_free: assert property (@(posedge clk) disable iff (!rst_n)
    (take && prefix_o && !flush) |=> (oreg_q[NIB_W-1:0] == '0));
  // R7: the register is frozen while nothing is taken and no flush occurs
  a_r7_oreg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !flush) |=> $stable(oreg_q));
endmodule

// File: rtl/opd_outreg.sv
module opd_outreg
  import opd_pkg::*;
#(
  parameter int unsigned OPW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             flush,
  input  logic             out_ready,
  input  logic [NIB_W-1:0] func_i,
  input  logic [OPW-1:0]   operand_i,
  output logic             valid_o,
  output logic [NIB_W-1:0] func_o,
  output logic [OPW-1:0]   operand_o,
  output logic             is_op_o,
  output logic [NIB_W-1:0] op_code_o,
  output logic             op_ext_o
);
  logic valid_q, valid_d;
  logic [NIB_W-1:0] func_q;
  logic [OPW-1:0] opnd_q;

  always_comb begin
    valid_d = valid_q;
    if (flush)          valid_d = 1'b0;
    else if (load)      valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      opnd_q <= '0;
    end else if (load && !flush) begin
      func_q <= func_i;
      opnd_q <= operand_i;
    end
  end

  assign valid_o   = valid_q;
  assign func_o    = func_q;
  assign operand_o = opnd_q;
  assign is_op_o   = (func_e'(func_q) == FN_OPERATE);
  assign op_code_o = opnd_q[NIB_W-1:0];
  assign op_ext_o  = |opnd_q[OPW-1:NIB_W];

  // R7: a blocked record holds still
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready && !flush) |=>
      (valid_q && $stable(opnd_q) && $stable(func_q)));
  // R8: flush empties the output register
  a_r8_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid_q);
endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
  import opd_pkg::*;
#(
  parameter int unsigned OPW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_func,
  output logic [31:0] out_operand,
  output logic        out_is_op,
  output logic [3:0]  out_op_code,
  output logic        out_op_ext
);
  logic [1:0] rst_sync_q;
  logic rst_sn;
  logic take, is_prefix;
  logic [OPW-1:0] cur_operand, rec_operand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign in_ready = !flush && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  opd_accum #(.OPW(OPW)) u_accum (
    .clk(clk), .rst_n(rst_sn), .take(take), .flush(flush),
    .byte_i(in_byte), .prefix_o(is_prefix), .operand_o(cur_operand)
  );

  opd_outreg #(.OPW(OPW)) u_out (
    .clk(clk), .rst_n(rst_sn), .load(take && !is_prefix), .flush(flush),
    .out_ready(out_ready), .func_i(in_byte[BYTE_W-1:NIB_W]),
    .operand_i(cur_operand), .valid_o(out_valid), .func_o(out_func),
    .operand_o(rec_operand), .is_op_o(out_is_op), .op_code_o(out_op_code),
    .op_ext_o(out_op_ext)
  );

  assign out_operand = rec_operand[31:0];

  // R7: no byte is taken while the output is blocked
  a_r7_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |-> !in_ready);
  // R10: a completing byte yields a record on the next cycle
  a_r10_record_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    (take && !is_prefix) |=> out_valid);
endmodule

// File: tb/test_opnd_decoder.sv
`timescale 1ns/100ps
module test_opnd_decoder;
  logic clk = 1'b0;
  logic rst_n, flush, in_valid, out_ready;
  logic [7:0] in_byte;
  logic in_ready, out_valid, out_is_op, out_op_ext;
  logic [3:0] out_func, out_op_code;
  logic [31:0] out_operand;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  opnd_decoder i_opnd_decoder (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_func(out_func), .out_operand(out_operand),
    .out_is_op(out_is_op), .out_op_code(out_op_code), .out_op_ext(out_op_ext)
  );

  // {byte, emits, func, operand}
  localparam int NV = 27;
  localparam logic [44:0] VEC [NV] = '{
    {8'h45, 1'b1, 4'h4, 32'h0000_0005},
    {8'h21, 1'b0, 4'h0, 32'h0},
    {8'h42, 1'b1, 4'h4, 32'h0000_0012},
    {8'h60, 1'b0, 4'h0, 32'h0},
    {8'h4F, 1'b1, 4'h4, 32'hFFFF_FFFF},
    {8'h6F, 1'b0, 4'h0, 32'h0},
    {8'h40, 1'b1, 4'h4, 32'hFFFF_FF00},
    {8'h21, 1'b0, 4'h0, 32'h0},
    {8'h22, 1'b0, 4'h0, 32'h0},
    {8'h83, 1'b1, 4'h8, 32'h0000_0123},
    {8'hF5, 1'b1, 4'hF, 32'h0000_0005},
    {8'h21, 1'b0, 4'h0, 32'h0},
    {8'hF0, 1'b1, 4'hF, 32'h0000_0010},
    {8'h61, 1'b0, 4'h0, 32'h0},
    {8'h22, 1'b0, 4'h0, 32'h0},
    {8'h73, 1'b1, 4'h7, 32'hFFFF_FE23},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h0F, 1'b1, 4'h0, 32'hFFFF_FFFF},
    {8'h9A, 1'b1, 4'h9, 32'h0000_000A}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int idx, input logic [7:0] b,
                                   input logic emit, input logic [3:0] fn);
    if (idx == 25) return "R6";
    if (!emit) return (b[7:4] == 4'h2) ? "R2" : "R3";
    if (fn == 4'hF) return "R5";
    if (idx == 0 || idx == 26) return "R1";
    return "R4";
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R9", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    // table walk, output always ready
    for (int i = 0; i < NV; i++) begin
      logic [7:0] b;
      logic em;
      logic [3:0] fn;
      logic [31:0] op;
      string t;
      {b, em, fn, op} = VEC[i];
      t = tag_of(i, b, em, fn);
      send(b);
      check(t, "out_valid", {31'd0, out_valid}, {31'd0, em});
      if (em) begin
        check(t, "out_func", {28'd0, out_func}, {28'd0, fn});
        check(t, "out_operand", out_operand, op);
        check("R5", "out_is_op", {31'd0, out_is_op}, {31'd0, (fn == 4'hF)});
        if (fn == 4'hF) begin
          check("R5", "out_op_code", {28'd0, out_op_code}, {28'd0, op[3:0]});
          check("R5", "out_op_ext", {31'd0, out_op_ext}, {31'd0, (op >= 32'd16)});
        end
      end
    end
    @(negedge clk);
    check("R10", "out_valid drains", {31'd0, out_valid}, 32'd0);

    // stall: record held, prefix waits
    out_ready = 1'b0;
    send(8'h41);
    check("R10", "record next cycle", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b1; in_byte = 8'h23;
    repeat (3) @(negedge clk);
    check("R7", "in_ready stalled", {31'd0, in_ready}, 32'd0);
    check("R7", "operand held", out_operand, 32'h1);
    check("R7", "valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "drain after handshake", {31'd0, out_valid}, 32'd0);
    send(8'h44);
    check("R7", "prefix applied once", out_operand, 32'h34);

    // flush drops partial operand
    send(8'h25);
    flush = 1'b1;
    #0.1;
    check("R8", "in_ready during flush", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
    send(8'h42);
    check("R8", "operand after flush", out_operand, 32'h2);

    // flush drops pending record
    out_ready = 1'b0;
    send(8'h47);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R8", "record dropped", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b1;

    // reset mid chain
    send(8'h29);
    rst_n = 1'b0;
    #0.5;
    check("R9", "out_valid async reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(8'h41);
    check("R9", "operand cleared by reset", out_operand, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule